// File: doc/BRIEF.md
# Configurable Secondary Cache Tag Controller

This block makes the tag and dirty-state decisions for a direct-mapped secondary cache and runs the memory-side sequence for each processor access. It holds an 8-bit tag word per line, a valid bit per line, and an optional 1-bit dirty store. A two-bit configuration input selects one of four policies:

- write-through;
- write-back with full 8-bit tags and no dirty information, so every valid victim is treated as dirty;
- write-back where the top bit of the tag word is used as the dirty flag and only 7 bits are compared, which halves the cacheable range;
- write-back with full 8-bit tags and the separate dirty store.

The processor presents an address and a read/write flag with a one-cycle valid pulse, then waits for a one-cycle ready pulse. On the memory side the block asks for a victim write-back, a line fill, or a single uncached access. Each request is held until its acknowledge arrives. Data storage is outside the block.

Top module: `l2_tag_ctrl`

## Requirements
- R1: After reset, every line is invalid, `cpu_ready`, `wb_req`, `fill_req` and `thru_req` are low, and the first miss on any index fills without a write-back.
- R2: Address fields are: byte offset = bits [3:0]; index = the next IDX_W bits; tag = the 8 bits above the index. With full tags an address is cacheable only when all bits above the tag are zero. In split mode only the low 7 tag bits are compared, and the address is cacheable only when tag bit 7 and everything above it are zero. An uncacheable access makes one bypass request (`thru_req`, with `thru_we` equal to the access's write flag and `thru_addr` equal to its address) and allocates no line.
- R3: `cfg_mode` encodes the policy: 0 is write-through, 1 is write-back with no dirty information, 2 is write-back with the split 7+1 tag, and 3 is write-back with full tags and the separate dirty store.
- R4: In write-through mode:
  - a read miss fills without a write-back;
  - every write, hit or miss, goes out as a bypass write;
  - a write miss allocates no line;
  - no write-back is ever requested.
- R5: In mode 1, a miss on an index that holds a valid line always writes that line back before the fill.
- R6: In modes 2 and 3:
  - a write hit marks the line dirty;
  - a read fill leaves the line clean;
  - a write miss fills and then leaves the line dirty;
  - a miss on a dirty victim writes it back and then fills, while a miss on a clean victim only fills.
- R7: `wb_line` is the victim's line address (zeros above the tag, the stored tag with bit 7 forced to 0 in split mode, then the index). `fill_line` is the requested line address (the access address without its 4 offset bits).
- R8: Every memory-side request stays high with a stable address until the cycle its acknowledge is seen.
- R9: `cpu_ready` is high for exactly one cycle, and only after the access's memory requests are complete. At most one of `wb_req`, `fill_req`, `thru_req` and `cpu_ready` is high in any cycle.
- R10: A change of `cfg_mode` takes effect between accesses and invalidates all lines.
- R11: A cacheable hit that needs no memory traffic (any read hit, or a write hit in a write-back mode) answers with `cpu_ready` two cycles after the request, with no memory request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_mode | input | 2 | Policy select (R3 encoding) |
| cpu_valid | input | 1 | Access request pulse, sampled while idle |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | ADDR_W | Byte address of the access |
| cpu_ready | output | 1 | One-cycle completion pulse |
| wb_req | output | 1 | Victim write-back request |
| wb_line | output | ADDR_W-4 | Line address being written back |
| wb_ack | input | 1 | Write-back done |
| fill_req | output | 1 | Line fill request |
| fill_line | output | ADDR_W-4 | Line address to fill |
| fill_ack | input | 1 | Fill done |
| thru_req | output | 1 | Single uncached or write-through access |
| thru_we | output | 1 | Write flag of the bypass access |
| thru_addr | output | ADDR_W | Address of the bypass access |
| thru_ack | input | 1 | Bypass access done |

## Verification
The two functions that can fall on one access are victim write-back and line fill. A miss on a dirty (or, in mode 1, any valid) victim must issue the write-back first and the fill immediately after it, never together. The bench provokes this by filling one line and then touching a second tag at the same index in each write-back mode. It judges the result from the order of the logged requests, the line addresses carried by each, and the one-hot rule that holds across every request and `cpu_ready`.

// File: rtl/l2t_pkg.sv
package l2t_pkg;
  typedef enum logic [1:0] {
    MODE_WT      = 2'd0,
    MODE_WB_NODR = 2'd1,
    MODE_WB_SPLT = 2'd2,
    MODE_WB_DSTR = 2'd3
  } l2t_mode_e;

  typedef enum logic [2:0] {
    ST_IDLE    = 3'd0,
    ST_LOOKUP  = 3'd1,
    ST_WRBACK  = 3'd2,
    ST_FILL    = 3'd3,
    ST_RESPOND = 3'd4
  } l2t_state_e;
endpackage

// File: rtl/l2t_store.sv
module l2t_store #(
  parameter int IDX_W = 6,
  parameter int TAG_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] idx,
  input  logic             clear_all,
  input  logic             valid_set,
  input  logic             tag_we,
  input  logic [TAG_W-1:0] tag_wdata,
  input  logic             dirty_we,
  input  logic             dirty_wdata,
  output logic [TAG_W-1:0] rd_tag,
  output logic             rd_dirty,
  output logic             rd_valid
);
  localparam int LINES = 1 << IDX_W;

  logic [LINES-1:0] valid_q;
  logic [TAG_W-1:0] tag_mem [LINES];
  logic [LINES-1:0] dirty_mem;

  // valid bits are the only reset state; arrays need none
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         valid_q <= '0;
    else if (clear_all) valid_q <= '0;
    else if (valid_set) valid_q[idx] <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (tag_we)   tag_mem[idx]   <= tag_wdata;
    if (dirty_we) dirty_mem[idx] <= dirty_wdata;
  end

  assign rd_tag   = tag_mem[idx];
  assign rd_dirty = dirty_mem[idx];
  assign rd_valid = valid_q[idx];
endmodule

// File: rtl/l2t_match.sv
module l2t_match
  import l2t_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int OFS_W  = 4,
  parameter int IDX_W  = 6,
  parameter int TAG_W  = 8
) (
  input  l2t_mode_e               mode,
  input  logic [ADDR_W-OFS_W-1:0] line_addr,
  input  logic [TAG_W-1:0]        rd_tag,
  input  logic                    rd_dirty,
  input  logic                    rd_valid,
  output logic                    cacheable,
  output logic                    hit,
  output logic                    victim_dirty,
  output logic [ADDR_W-OFS_W-1:0] victim_line
);
  localparam int LINE_W = ADDR_W - OFS_W;
  localparam int HI_W   = LINE_W - IDX_W - TAG_W;  // must be at least 1

  logic [TAG_W-1:0] a_tag;
  logic [HI_W-1:0]  a_hi;
  logic [IDX_W-1:0] a_idx;
  logic             split, match;
  logic [TAG_W-1:0] v_tag;

  assign a_idx = line_addr[IDX_W-1:0];
  assign a_tag = line_addr[IDX_W +: TAG_W];
  assign a_hi  = line_addr[LINE_W-1 -: HI_W];
  assign split = (mode == MODE_WB_SPLT);

  always_comb begin
    cacheable = (a_hi == '0) && (!split || !a_tag[TAG_W-1]);
    match     = split ? (rd_tag[TAG_W-2:0] == a_tag[TAG_W-2:0]) : (rd_tag == a_tag);
    hit       = rd_valid && match && cacheable;
    v_tag     = split ? {1'b0, rd_tag[TAG_W-2:0]} : rd_tag;
    unique case (mode)
      MODE_WT:      victim_dirty = 1'b0;
      MODE_WB_NODR: victim_dirty = rd_valid;
      MODE_WB_SPLT: victim_dirty = rd_valid && rd_tag[TAG_W-1];
      default:      victim_dirty = rd_valid && rd_dirty;
    endcase
  end

  assign victim_line = {{HI_W{1'b0}}, v_tag, a_idx};
endmodule

// File: rtl/l2t_seq.sv
module l2t_seq
  import l2t_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int OFS_W  = 4,
  parameter int IDX_W  = 6,
  parameter int TAG_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        cfg_mode,
  input  logic              cpu_valid,
  input  logic              cpu_we,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic              cacheable,
  input  logic              hit,
  input  logic              victim_dirty,
  input  logic              wb_ack,
  input  logic              fill_ack,
  input  logic              thru_ack,
  output l2t_mode_e         mode_q,
  output logic [ADDR_W-1:0] addr_q,
  output logic              clear_all,
  output logic              valid_set,
  output logic              tag_we,
  output logic [TAG_W-1:0]  tag_wdata,
  output logic              dirty_we,
  output logic              dirty_wdata,
  output logic              wb_req,
  output logic              fill_req,
  output logic              thru_req,
  output logic              thru_we,
  output logic              cpu_ready
);
  localparam int TAG_LO = OFS_W + IDX_W;

  l2t_state_e       state_q, state_d;
  logic             we_q, byp_q, byp_d, req_ld, mode_ld;
  logic [TAG_W-1:0] a_tag;
  logic             wt, split;

  assign a_tag = addr_q[TAG_LO +: TAG_W];
  assign wt    = (mode_q == MODE_WT);
  assign split = (mode_q == MODE_WB_SPLT);

  always_comb begin
    state_d     = state_q;
    byp_d       = byp_q;
    req_ld      = 1'b0;
    mode_ld     = (state_q == ST_IDLE);
    clear_all   = (state_q == ST_IDLE) && (l2t_mode_e'(cfg_mode) != mode_q);
    valid_set   = 1'b0;
    tag_we      = 1'b0;
    tag_wdata   = a_tag;
    dirty_we    = 1'b0;
    dirty_wdata = 1'b0;
    unique case (state_q)
      ST_IDLE: if (cpu_valid) begin
        req_ld  = 1'b1;
        state_d = ST_LOOKUP;
      end
      ST_LOOKUP: begin
        byp_d = 1'b0;
        if (!cacheable || (wt && we_q)) begin
          byp_d   = 1'b1;
          state_d = ST_FILL;
        end else if (hit) begin
          if (we_q && split) begin
            tag_we    = 1'b1;
            tag_wdata = {1'b1, a_tag[TAG_W-2:0]};
          end
          if (we_q && mode_q == MODE_WB_DSTR) begin
            dirty_we    = 1'b1;
            dirty_wdata = 1'b1;
          end
          state_d = ST_RESPOND;
        end else if (victim_dirty) begin
          state_d = ST_WRBACK;
        end else begin
          state_d = ST_FILL;
        end
      end
      ST_WRBACK: if (wb_ack) state_d = ST_FILL;
      ST_FILL: begin
        if (byp_q) begin
          if (thru_ack) state_d = ST_RESPOND;
        end else if (fill_ack) begin
          valid_set   = 1'b1;
          tag_we      = 1'b1;
          tag_wdata   = split ? {we_q, a_tag[TAG_W-2:0]} : a_tag;
          dirty_we    = (mode_q == MODE_WB_DSTR);
          dirty_wdata = we_q;
          state_d     = ST_RESPOND;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      byp_q   <= 1'b0;
      we_q    <= 1'b0;
      addr_q  <= '0;
      mode_q  <= MODE_WT;
    end else begin
      state_q <= state_d;
      byp_q   <= byp_d;
      if (req_ld) begin
        we_q   <= cpu_we;
        addr_q <= cpu_addr;
      end
      if (mode_ld) mode_q <= l2t_mode_e'(cfg_mode);
    end
  end

  assign wb_req    = (state_q == ST_WRBACK);
  assign fill_req  = (state_q == ST_FILL) && !byp_q;
  assign thru_req  = (state_q == ST_FILL) && byp_q;
  assign thru_we   = thru_req && we_q;
  assign cpu_ready = (state_q == ST_RESPOND);
endmodule

// File: rtl/l2_tag_ctrl.sv
module l2_tag_ctrl
  import l2t_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int OFS_W  = 4,
  parameter int IDX_W  = 6,
  parameter int TAG_W  = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [1:0]              cfg_mode,
  input  logic                    cpu_valid,
  input  logic                    cpu_we,
  input  logic [ADDR_W-1:0]       cpu_addr,
  output logic                    cpu_ready,
  output logic                    wb_req,
  output logic [ADDR_W-OFS_W-1:0] wb_line,
  input  logic                    wb_ack,
  output logic                    fill_req,
  output logic [ADDR_W-OFS_W-1:0] fill_line,
  input  logic                    fill_ack,
  output logic                    thru_req,
  output logic                    thru_we,
  output logic [ADDR_W-1:0]       thru_addr,
  input  logic                    thru_ack
);
  l2t_mode_e        mode_q;
  logic [ADDR_W-1:0] addr_q;
  logic             clear_all, valid_set, tag_we, dirty_we, dirty_wdata;
  logic [TAG_W-1:0] tag_wdata, rd_tag;
  logic             rd_dirty, rd_valid, cacheable, hit, victim_dirty;

  l2t_seq #(.ADDR_W(ADDR_W), .OFS_W(OFS_W), .IDX_W(IDX_W), .TAG_W(TAG_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .cfg_mode(cfg_mode),
    .cpu_valid(cpu_valid), .cpu_we(cpu_we), .cpu_addr(cpu_addr),
    .cacheable(cacheable), .hit(hit), .victim_dirty(victim_dirty),
    .wb_ack(wb_ack), .fill_ack(fill_ack), .thru_ack(thru_ack),
    .mode_q(mode_q), .addr_q(addr_q), .clear_all(clear_all), .valid_set(valid_set),
    .tag_we(tag_we), .tag_wdata(tag_wdata), .dirty_we(dirty_we), .dirty_wdata(dirty_wdata),
    .wb_req(wb_req), .fill_req(fill_req), .thru_req(thru_req), .thru_we(thru_we),
    .cpu_ready(cpu_ready)
  );

  l2t_store #(.IDX_W(IDX_W), .TAG_W(TAG_W)) u_store (
    .clk(clk), .rst_n(rst_n), .idx(addr_q[OFS_W +: IDX_W]),
    .clear_all(clear_all), .valid_set(valid_set),
    .tag_we(tag_we), .tag_wdata(tag_wdata),
    .dirty_we(dirty_we), .dirty_wdata(dirty_wdata),
    .rd_tag(rd_tag), .rd_dirty(rd_dirty), .rd_valid(rd_valid)
  );

  l2t_match #(.ADDR_W(ADDR_W), .OFS_W(OFS_W), .IDX_W(IDX_W), .TAG_W(TAG_W)) u_match (
    .mode(mode_q), .line_addr(addr_q[ADDR_W-1:OFS_W]),
    .rd_tag(rd_tag), .rd_dirty(rd_dirty), .rd_valid(rd_valid),
    .cacheable(cacheable), .hit(hit), .victim_dirty(victim_dirty),
    .victim_line(wb_line)
  );

  assign fill_line = addr_q[ADDR_W-1:OFS_W];
  assign thru_addr = addr_q;
endmodule

// File: rtl/l2t_chk.sv
module l2t_chk #(
  parameter int ADDR_W = 20,
  parameter int LINE_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic [1:0]        mode_q,
  input logic              cpu_ready,
  input logic              wb_req,
  input logic [LINE_W-1:0] wb_line,
  input logic              wb_ack,
  input logic              fill_req,
  input logic [LINE_W-1:0] fill_line,
  input logic              fill_ack,
  input logic              thru_req,
  input logic [ADDR_W-1:0] thru_addr,
  input logic              thru_ack
);
  a_r8_wb_hold: assert property (@(posedge clk) disable iff (!rst_n)
    wb_req && !wb_ack |=> wb_req && $stable(wb_line));
  a_r8_fill_hold: assert property (@(posedge clk) disable iff (!rst_n)
    fill_req && !fill_ack |=> fill_req && $stable(fill_line));
  a_r8_thru_hold: assert property (@(posedge clk) disable iff (!rst_n)
    thru_req && !thru_ack |=> thru_req && $stable(thru_addr));
  a_r9_one_active: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({wb_req, fill_req, thru_req, cpu_ready}));
  a_r9_ready_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_ready |=> !cpu_ready);
  a_r4_wt_no_wb: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == 2'd0) |-> !wb_req);
  a_r6_wb_then_fill: assert property (@(posedge clk) disable iff (!rst_n)
    wb_req && wb_ack |=> fill_req);
endmodule

bind l2_tag_ctrl l2t_chk #(.ADDR_W(ADDR_W), .LINE_W(ADDR_W - OFS_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .mode_q(mode_q), .cpu_ready(cpu_ready),
  .wb_req(wb_req), .wb_line(wb_line), .wb_ack(wb_ack),
  .fill_req(fill_req), .fill_line(fill_line), .fill_ack(fill_ack),
  .thru_req(thru_req), .thru_addr(thru_addr), .thru_ack(thru_ack)
);

// File: tb/sim_l2_tag_ctrl.sv
module sim_l2_tag_ctrl;
  localparam int AW = 20;
  localparam int LW = 16;

  logic clk, rst_n, cpu_valid, cpu_we, cpu_ready;
  logic [1:0] cfg_mode;
  logic [AW-1:0] cpu_addr, thru_addr;
  logic wb_req, wb_ack, fill_req, fill_ack, thru_req, thru_we, thru_ack;
  logic [LW-1:0] wb_line, fill_line;

  int checks = 0, errors = 0, cycles = 0;
  int ev_n;
  int ev [4];
  logic [LW-1:0] got_wb, got_fill;
  logic [AW-1:0] got_thru;
  logic got_twe;

  l2_tag_ctrl u0 (.*);

  initial clk = 1'b0;
  always #10 clk = ~clk;

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 20000) begin
      errors = errors + 1;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  function automatic logic [AW-1:0] mk(input int hi, input int tg, input int ix);
    logic [AW-1:0] a;
    a = {hi[1:0], tg[7:0], ix[5:0], 4'h0};
    return a;
  endfunction

  task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", rq, act, exp);
    end
  endtask

  task automatic set_mode(input logic [1:0] m);
    @(negedge clk);
    cfg_mode = m;
    repeat (2) @(negedge clk);
  endtask

  // events: 1 = write-back, 2 = fill, 3 = bypass
  task automatic access(input logic we, input logic [AW-1:0] a, input int n,
                        input int e0, input int e1, input string rq);
    bit done = 0;
    bit was;
    ev_n = 0;
    @(negedge clk);
    cpu_valid = 1'b1; cpu_we = we; cpu_addr = a;
    @(negedge clk);
    cpu_valid = 1'b0;
    for (int i = 0; i < 100 && !done; i++) begin
      if (i > 0) @(negedge clk);
      was = wb_ack | fill_ack | thru_ack;
      wb_ack = 0; fill_ack = 0; thru_ack = 0;
      if (cpu_ready) done = 1;
      else if (!was) begin
        if (wb_req) begin
          got_wb = wb_line; wb_ack = 1; if (ev_n < 4) ev[ev_n] = 1; ev_n++;
        end else if (fill_req) begin
          got_fill = fill_line; fill_ack = 1; if (ev_n < 4) ev[ev_n] = 2; ev_n++;
        end else if (thru_req) begin
          got_thru = thru_addr; got_twe = thru_we; thru_ack = 1; if (ev_n < 4) ev[ev_n] = 3; ev_n++;
        end
      end
    end
    chk({rq, " ready seen"}, done, 1);
    chk({rq, " request count"}, ev_n, n);
    if (n > 0) chk({rq, " first request"}, ev[0], e0);
    if (n > 1) chk({rq, " second request"}, ev[1], e1);
    @(negedge clk);
    chk("R9 ready one cycle", cpu_ready, 0);
  endtask

  task automatic t_reset();
    chk("R1 ready low", cpu_ready, 0);
    chk("R1 no requests", {wb_req, fill_req, thru_req}, 0);
  endtask

  task automatic t_write_through();
    logic [AW-1:0] a, b;
    a = mk(0, 8'h12, 5); b = mk(0, 8'h13, 5);
    set_mode(2'd0);
    access(0, a, 1, 2, 0, "R4 R1 R3 wt read miss fill only");
    chk("R7 fill line", got_fill, a[AW-1:4]);
    access(0, a, 0, 0, 0, "R11 wt read hit");
    access(1, a, 1, 3, 0, "R4 wt write hit bypass");
    chk("R4 bypass write flag", got_twe, 1);
    access(1, b, 1, 3, 0, "R4 wt write miss bypass");
    access(0, a, 0, 0, 0, "R4 write miss no allocate");
    access(0, b, 1, 2, 0, "R4 wt read miss no writeback");
  endtask

  task automatic t_no_dirty();
    logic [AW-1:0] a, b;
    a = mk(0, 8'h12, 5); b = mk(0, 8'h13, 5);
    set_mode(2'd1);
    access(0, a, 1, 2, 0, "R10 mode change invalidated");
    access(0, b, 2, 1, 2, "R5 clean victim still written back");
    chk("R7 wb line", got_wb, a[AW-1:4]);
    chk("R7 fill line after wb", got_fill, b[AW-1:4]);
    access(0, b, 0, 0, 0, "R11 mode1 hit");
  endtask

  task automatic t_split();
    logic [AW-1:0] a, b, c, u;
    a = mk(0, 8'h12, 5); b = mk(0, 8'h13, 5); c = mk(0, 8'h21, 5); u = mk(0, 8'h80, 9);
    set_mode(2'd2);
    access(0, a, 1, 2, 0, "R6 split read fill");
    access(0, b, 1, 2, 0, "R6 clean victim fill only");
    access(1, b, 0, 0, 0, "R11 R6 write hit sets dirty");
    access(0, a, 2, 1, 2, "R6 dirty victim written back");
    chk("R7 split wb line", got_wb, b[AW-1:4]);
    access(1, c, 1, 2, 0, "R6 write miss fill");
    access(0, a, 2, 1, 2, "R6 write miss left dirty");
    chk("R7 wb line after write miss", got_wb, c[AW-1:4]);
    access(0, u, 1, 3, 0, "R2 split uncacheable bypass");
    chk("R2 bypass addr", got_thru, u);
    chk("R2 bypass read flag", got_twe, 0);
    access(0, u, 1, 3, 0, "R2 uncacheable not allocated");
  endtask

  task automatic t_dstore();
    logic [AW-1:0] u, v;
    u = mk(0, 8'h80, 9); v = mk(0, 8'h00, 9);
    set_mode(2'd3);
    access(0, u, 1, 2, 0, "R2 full tag caches bit7 tag");
    access(1, v, 1, 2, 0, "R2 R6 full compare, clean victim");
    access(0, u, 2, 1, 2, "R6 dirty store victim written back");
    chk("R7 dstore wb line", got_wb, v[AW-1:4]);
    access(0, u, 0, 0, 0, "R11 dstore hit");
  endtask

  task automatic t_bypass();
    logic [AW-1:0] h, x;
    h = mk(0, 8'h33, 12); x = mk(1, 8'h33, 12);
    set_mode(2'd1);
    access(0, h, 1, 2, 0, "R2 mode1 fill");
    access(1, x, 1, 3, 0, "R2 out-of-range write bypass");
    chk("R2 bypass write addr", got_thru, x);
    chk("R2 bypass write flag", got_twe, 1);
    access(0, h, 0, 0, 0, "R2 bypass left line intact");
  endtask

  initial begin
    rst_n = 0; cfg_mode = 2'd0; cpu_valid = 0; cpu_we = 0; cpu_addr = '0;
    wb_ack = 0; fill_ack = 0; thru_ack = 0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_write_through();
    t_no_dirty();
    t_split();
    t_dstore();
    t_bypass();
    repeat (2) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule